// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block gathers interrupt requests from a small set of dedicated external interrupt pins and from a wider bank of general-purpose pins. The general pins are split into pin-change groups of up to eight pins each. With the default 27 pins the groups hold 8, 8, 8 and 3 pins. Each external pin is sensed according to a static two-bit mode: low level, any change, falling edge or rising edge. In the three edge modes a matching event latches a flag. The flags are visible in a byte-wide flag register. Software clears a flag by writing a one to its bit, and the CPU's vector acknowledge also clears it. In low-level mode the flag is forced to zero, and the request follows the synchronized pin directly.

A change on any unmasked pin of a group sets that group's internal pending bit. The bit stays set until the group's vector acknowledge arrives. A byte-wide group-enable register, together with the global interrupt enable, decides whether a pending group reaches the CPU. Every pin first passes through a two-flop synchronizer. All request outputs are registered. Register reads return data one cycle after the read strobe.

Top module: `irq_sense_unit`

## Requirements
- R1: After synchronous reset, every request output is zero. The flag register and the group-enable register both read 0x00.
- R2: Register address 0 selects the flag register and address 1 selects the group-enable register. Read data appears on the clock edge that samples the read strobe. Bits 7..4 of both registers always read as zero.
- R3: Mode 2'b11 sets the pin's flag on a rising edge and mode 2'b10 on a falling edge. Mode 2'b01 sets it on either edge. The mode of pin i sits in ext_mode[2i+1:2i]. The flag and request rise on the third rising clock edge after the pin changes, and not earlier.
- R4: In mode 2'b00 the pin's flag is held at zero, and a flag set earlier is cleared. The request for that pin is high while the synchronized pin is low and both its enable and the global enable are one.
- R5: In edge modes, req_ext[i] is one exactly when flag i is set, ext_en[i] is one and glob_ie is one. A request suppressed by the enables appears one cycle after the enables return, and the flag is kept meanwhile.
- R6: A write to address 0 clears each flag whose data bit is one. Flags whose data bit is zero are left unchanged.
- R7: A pulse on ack_ext[i] clears flag i, and its request drops on the same edge.
- R8: When a set event and a clear, by write or by acknowledge, hit the same flag in the same cycle, the flag stays one.
- R9: Group g covers pc_pin[8g+7:8g], and the last group covers only the remaining pins (26..24 by default). A change on an unmasked pin sets the group's pending bit. req_pc[g] is one when that bit is set, group-enable bit g is one and glob_ie is one. ack_pc[g] clears the pending bit.
- R10: A change on a pin whose pc_mask bit is zero has no effect on any group request.
- R11: A write to address 1 loads group-enable bits 3..0 from the write data. The register changes on no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | External interrupt pins (asynchronous) |
| ext_mode | input | 8 | Static sense mode, two bits per external pin |
| ext_en | input | 4 | Individual enable per external interrupt |
| glob_ie | input | 1 | Global interrupt enable |
| pc_pin | input | 27 | Pin-change pins (asynchronous) |
| pc_mask | input | 27 | Per-pin change mask, 1 = pin participates |
| reg_addr | input | 1 | Register select: 0 flags, 1 group enable |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| ack_ext | input | 4 | Vector acknowledge per external interrupt |
| ack_pc | input | 4 | Vector acknowledge per pin-change group |
| req_ext | output | 4 | Registered request per external interrupt |
| req_pc | output | 4 | Registered request per pin-change group |

## Verification
The two functions that can fall in the same cycle are the setting of a flag by a detected edge and its clearing by an acknowledge or a write-one. The bench provokes the collision by counting clock edges from a pin toggle. It asserts the acknowledge, and in a second run the write strobe, during exactly the cycle in which the synchronized edge is detected. It judges the result by checking that the request stays high and that a later register read still shows the flag.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_ANY   = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_RISE  = 2'b11
  } sense_e;

  // Number of pins in group g when n pins are split into groups of sz
  function automatic int grp_width(input int g, input int n, input int sz);
    int rest;
    rest = n - g * sz;
    return (rest < sz) ? rest : sz;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync = sync_q;
  assign prev = prev_q;
endmodule

// File: rtl/irq_ext_chan.sv
module irq_ext_chan
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       pin_s,
  input  logic       pin_p,
  input  logic       wr_clr,
  input  logic       ack,
  input  logic       en,
  input  logic       gie,
  output logic       flag,
  output logic       req
);
  sense_e sense;
  logic   lvl, set_ev, flag_n, req_n, flag_q, req_q;

  assign sense = sense_e'(mode);
  assign lvl   = (sense == SENSE_LEVEL);

  always_comb begin
    case (sense)
      SENSE_ANY:  set_ev = pin_s ^ pin_p;
      SENSE_FALL: set_ev = pin_p & ~pin_s;
      SENSE_RISE: set_ev = pin_s & ~pin_p;
      default:    set_ev = 1'b0;
    endcase
  end

  assign flag_n = lvl ? 1'b0 : (set_ev | (flag_q & ~(wr_clr | ack)));
  assign req_n  = (lvl ? ~pin_s : flag_n) & en & gie;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      req_q  <= req_n;
    end
  end

  assign flag = flag_q;
  assign req  = req_q;

  // R4
  level_flag_low_chk: assert property (@(posedge clk) disable iff (rst)
    lvl |=> !flag_q);

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (set_ev && !lvl && (wr_clr || ack)) |=> flag_q);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_ev) |=> !flag_q);

  // R5
  req_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(gie && en));
endmodule

// File: rtl/irq_pc_group.sv
module irq_pc_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] pin_p,
  input  logic [W-1:0] mask,
  input  logic         grp_en,
  input  logic         gie,
  input  logic         ack,
  output logic         req
);
  logic hit, pend_n, pend_q, req_q;

  assign hit    = |((pin_s ^ pin_p) & mask);
  assign pend_n = hit | (pend_q & ~ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      req_q  <= pend_n & grp_en & gie;
    end
  end

  assign req = req_q;

  // R9
  grp_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit) |=> !pend_q);

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (((pin_s ^ pin_p) & mask) == '0 && !pend_q) |=> !req_q);

  // R9
  grp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |-> $past(grp_en && gie));
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
  import irq_pkg::*;
#(
  parameter int N_EXT  = 4,
  parameter int N_PC   = 27,
  parameter int GRP_SZ = 8,
  parameter int DW     = 8,
  parameter int N_GRP  = (N_PC + GRP_SZ - 1) / GRP_SZ
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_EXT-1:0]   ext_pin,
  input  logic [2*N_EXT-1:0] ext_mode,
  input  logic [N_EXT-1:0]   ext_en,
  input  logic               glob_ie,
  input  logic [N_PC-1:0]    pc_pin,
  input  logic [N_PC-1:0]    pc_mask,
  input  logic               reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [N_EXT-1:0]   ack_ext,
  input  logic [N_GRP-1:0]   ack_pc,
  output logic [N_EXT-1:0]   req_ext,
  output logic [N_GRP-1:0]   req_pc
);
  localparam int PAD_EXT = DW - N_EXT;
  localparam int PAD_GRP = DW - N_GRP;

  logic [N_EXT-1:0] ext_s, ext_p, flags;
  logic [N_PC-1:0]  pc_s, pc_p;
  logic [N_GRP-1:0] gen_q;
  logic [DW-1:0]    rdata_q;
  logic             wr_flags, wr_gen;

  assign wr_flags = reg_wr && (reg_addr == 1'b0);
  assign wr_gen   = reg_wr && (reg_addr == 1'b1);

  irq_sync #(.W(N_EXT)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_pin), .sync(ext_s), .prev(ext_p)
  );

  irq_sync #(.W(N_PC)) u_pc_sync (
    .clk(clk), .rst(rst), .din(pc_pin), .sync(pc_s), .prev(pc_p)
  );

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    irq_ext_chan u_chan (
      .clk   (clk),
      .rst   (rst),
      .mode  (ext_mode[2*i +: 2]),
      .pin_s (ext_s[i]),
      .pin_p (ext_p[i]),
      .wr_clr(wr_flags && reg_wdata[i]),
      .ack   (ack_ext[i]),
      .en    (ext_en[i]),
      .gie   (glob_ie),
      .flag  (flags[i]),
      .req   (req_ext[i])
    );
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int LO = g * GRP_SZ;
    localparam int GW = grp_width(g, N_PC, GRP_SZ);
    irq_pc_group #(.W(GW)) u_grp (
      .clk   (clk),
      .rst   (rst),
      .pin_s (pc_s[LO +: GW]),
      .pin_p (pc_p[LO +: GW]),
      .mask  (pc_mask[LO +: GW]),
      .grp_en(gen_q[g]),
      .gie   (glob_ie),
      .ack   (ack_pc[g]),
      .req   (req_pc[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_gen)
        gen_q <= reg_wdata[N_GRP-1:0];
      if (reg_rd)
        rdata_q <= reg_addr ? {{PAD_GRP{1'b0}}, gen_q}
                            : {{PAD_EXT{1'b0}}, flags};
    end
  end

  assign reg_rdata = rdata_q;

  // R11
  gen_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_gen |=> $stable(gen_q));
endmodule

// File: tb/test_irq_sense_unit.sv
module test_irq_sense_unit;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  ext_pin, ext_en, ack_ext, ack_pc, req_ext, req_pc;
  logic [7:0]  ext_mode, reg_wdata, reg_rdata;
  logic        glob_ie, reg_addr, reg_wr, reg_rd;
  logic [26:0] pc_pin, pc_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  irq_sense_unit i_irq_sense_unit (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_mode(ext_mode),
    .ext_en(ext_en), .glob_ie(glob_ie), .pc_pin(pc_pin), .pc_mask(pc_mask),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_ext(ack_ext),
    .ack_pc(ack_pc), .req_ext(req_ext), .req_pc(req_pc)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    tick(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic ack_e(input logic [3:0] m);
    ack_ext = m; tick(1); ack_ext = '0;
  endtask

  task automatic ack_g(input logic [3:0] m);
    ack_pc = m; tick(1); ack_pc = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 req_ext after reset", req_ext, 0);
    chk("R1 req_pc after reset", req_pc, 0);
    rd(1'b0, d); chk("R1 flags after reset", d, 0);
    rd(1'b1, d); chk("R1 group enable after reset", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(1'b1, 8'hFF); rd(1'b1, d); chk("R2 R11 gen reserved bits", d, 8'h0F);
    wr(1'b1, 8'h05); rd(1'b1, d); chk("R11 gen load", d, 8'h05);
    wr(1'b1, 8'h00); rd(1'b1, d); chk("R11 gen clear", d, 8'h00);
    wr(1'b0, 8'hFF); rd(1'b0, d); chk("R2 flag reserved bits", d, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    ext_pin[0] = 1'b1;
    tick(2); chk("R3 rise not before third edge", req_ext, 4'b0000);
    tick(1); chk("R3 rise on third edge", req_ext, 4'b0001);
    rd(1'b0, d); chk("R3 rise flag", d, 8'h01);
    ack_e(4'b0001); chk("R7 ack drops request", req_ext, 4'b0000);
    rd(1'b0, d); chk("R7 ack clears flag", d, 8'h00);
    ext_pin[0] = 1'b0; tick(4); chk("R3 falling ignored in rise mode", req_ext, 4'b0000);
    ext_mode[3:2] = 2'b10;
    ext_pin[1] = 1'b1; tick(4); chk("R3 rising ignored in fall mode", req_ext, 4'b0000);
    ext_pin[1] = 1'b0; tick(3); chk("R3 fall sets", req_ext, 4'b0010);
    wr(1'b0, 8'h00); chk("R6 write zero keeps", req_ext, 4'b0010);
    wr(1'b0, 8'h02); chk("R6 write one clears request", req_ext, 4'b0000);
    rd(1'b0, d); chk("R6 write one clears flag", d, 8'h00);
  endtask

  task automatic t_gate();
    logic [7:0] d;
    glob_ie = 1'b0;
    ext_pin[0] = 1'b1; tick(3);
    chk("R5 gie low blocks", req_ext, 4'b0000);
    rd(1'b0, d); chk("R5 flag kept while blocked", d, 8'h01);
    glob_ie = 1'b1; tick(1); chk("R5 request after gie", req_ext, 4'b0001);
    ext_en = 4'b1110; tick(1); chk("R5 enable low blocks", req_ext, 4'b0000);
    ext_en = 4'b1111; ack_e(4'b0001);
    ext_pin[0] = 1'b0; tick(4);
    chk("R5 idle", req_ext, 4'b0000);
  endtask

  task automatic t_level();
    logic [7:0] d;
    ext_pin[2] = 1'b1; tick(3); chk("R3 pin2 rise", req_ext, 4'b0100);
    ext_mode[5:4] = 2'b00; tick(1);
    chk("R4 level high no request", req_ext, 4'b0000);
    rd(1'b0, d); chk("R4 level forces flag low", d, 8'h00);
    ext_pin[2] = 1'b0; tick(3); chk("R4 level low requests", req_ext, 4'b0100);
    rd(1'b0, d); chk("R4 flag stays low in level", d, 8'h00);
    ext_pin[2] = 1'b1; tick(3); chk("R4 level release", req_ext, 4'b0000);
    ext_mode[5:4] = 2'b11; tick(2);
  endtask

  task automatic t_setwins();
    logic [7:0] d;
    ext_mode[7:6] = 2'b01;
    ext_pin[3] = 1'b1; tick(3); chk("R3 any-change rise", req_ext, 4'b1000);
    ext_pin[3] = 1'b0; tick(2);
    ack_e(4'b1000);
    chk("R8 set beats ack", req_ext, 4'b1000);
    rd(1'b0, d); chk("R8 flag after ack collision", d, 8'h08);
    ext_pin[3] = 1'b1; tick(2);
    wr(1'b0, 8'h08);
    chk("R8 set beats write-one", req_ext, 4'b1000);
    ack_e(4'b1000); chk("R7 clear after collisions", req_ext, 4'b0000);
  endtask

  task automatic t_groups();
    wr(1'b1, 8'h0F);
    for (int g = 0; g < 4; g++) begin
      int lo = 8 * g;
      int hi = (g == 3) ? 26 : 8 * g + 7;
      pc_pin[lo] = ~pc_pin[lo]; tick(2);
      chk($sformatf("R9 group %0d not early", g), req_pc, 0);
      tick(1); chk($sformatf("R9 group %0d low pin", g), req_pc, 1 << g);
      ack_g(4'(1 << g)); chk($sformatf("R9 group %0d ack", g), req_pc, 0);
      pc_pin[hi] = ~pc_pin[hi]; tick(3);
      chk($sformatf("R9 group %0d high pin", g), req_pc, 1 << g);
      ack_g(4'(1 << g));
      pc_mask[lo + 1] = 1'b0;
      pc_pin[lo + 1] = ~pc_pin[lo + 1]; tick(4);
      chk($sformatf("R10 group %0d masked pin", g), req_pc, 0);
    end
    wr(1'b1, 8'h00);
    pc_pin[0] = ~pc_pin[0]; tick(3);
    chk("R9 group disabled", req_pc, 0);
    wr(1'b1, 8'h01); chk("R9 enable takes one more edge", req_pc, 0);
    tick(1); chk("R9 pending shows after enable", req_pc, 4'b0001);
    ack_g(4'b0001); chk("R9 final ack", req_pc, 0);
  endtask

  initial begin
    rst = 1'b1; ext_pin = '0; ext_mode = 8'hFF; ext_en = 4'hF; glob_ie = 1'b1;
    pc_pin = '0; pc_mask = '1; reg_addr = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; ack_ext = '0; ack_pc = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_regs();
    t_edges();
    t_gate();
    t_level();
    t_setwins();
    t_groups();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule